// File: doc/BRIEF.md
# Hold/Toggle Duty-Cycle Sequencer

This block produces the single global mode signal that cuts the shift period of each test pattern into alternating hold and toggle intervals. A mode bit records the current state. A value of 1 means toggle: the latches downstream pass fresh generator data. A value of 0 means hold: every latch keeps its last value. A single down counter times each interval. Whenever the counter expires, the mode bit flips and the counter is preset from the duration code that belongs to the mode just entered. The interval lengths are therefore programmed by two small codes, one for hold and one for toggle.

At the start of every pattern, the mode bit is seeded with a chosen starting mode and the counter is seeded with an offset, so each pattern can begin anywhere in the duty cycle. One reserved hold code turns hold off completely, which keeps the mode output at toggle for the whole pattern. A one-cycle first-cycle strobe follows every pattern start, so that the latches can be reloaded with the current generator state.

Top module: `hold_toggle_sequencer`

## Requirements
- R1: While reset is applied, mode_o is 1 (toggle) for any non-zero hold code and first_cycle_o is 0.
- R2: A pattern start sampled on a clock edge sets mode_o to start_mode_i and loads the counter with offset_i, both taking effect in the following cycle.
- R3: first_cycle_o is 1 for exactly the one cycle that follows each clock edge at which pattern start was sampled, and 0 at all other times.
- R4: After a pattern start with offset value v, the starting mode lasts v+1 cycles before the mode flips.
- R5: A hold interval lasts hold_code_i+1 cycles and a toggle interval lasts toggle_code_i+1 cycles. The code is sampled in the cycle in which the counter expires and the mode flips into that interval.
- R6: A duration code or offset of 0 gives an interval of exactly one cycle.
- R7: A hold code of 4'b0000 forces mode_o to 1 for as long as that code is applied. The counter and mode sequencing go on underneath, and they show again at mode_o once a non-zero hold code is applied.
- R8: When a pattern start coincides with counter expiry, the pattern start wins: the mode takes start_mode_i and the counter takes offset_i.
- R9: A change to a duration code during an interval does not shorten or lengthen that interval. It only affects the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pat_start_i | input | 1 | Pattern start: seeds mode and counter |
| hold_code_i | input | 4 | Hold interval code (length = code+1); 0 means no hold |
| toggle_code_i | input | 4 | Toggle interval code (length = code+1) |
| start_mode_i | input | 1 | Starting mode for the pattern (1 toggle, 0 hold) |
| offset_i | input | 4 | Initial counter value for the pattern |
| mode_o | output | 1 | Current mode: 1 toggle, 0 hold |
| first_cycle_o | output | 1 | One-cycle strobe in the cycle after a pattern start |

## Verification
The hardest case to reach from the ports is a pattern start that lands exactly on counter expiry. Only careful counting makes the two events line up. The bench reaches it in a directed way: it starts a pattern with offset 0 and issues a second start on the very next edge. It also issues starts at random against a running model, which often hits the same coincidence. A second hard case is a duration code that changes in the middle of an interval, to show that the code is sampled only at reload. This is driven both in a directed way and by the random stimulus, which changes codes every cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned SEQ_CNT_W_DEF = 4;

  typedef enum logic {
    SEQ_HOLD   = 1'b0,
    SEQ_TOGGLE = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/seq_reset_sync.sv
module seq_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/seq_mode_tff.sv
module seq_mode_tff
  import seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      init_i,
  input  seq_mode_e init_mode_i,
  input  logic      flip_i,
  output seq_mode_e mode_o
);
  seq_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (init_i)      mode_d = init_mode_i;
    else if (flip_i) mode_d = seq_mode_e'(~mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SEQ_TOGGLE;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  p_flip_on_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && flip_i) |=> (mode_q != $past(mode_q)));
  p_steady_mid_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !flip_i) |=> $stable(mode_q));
endmodule

// File: rtl/seq_phase_counter.sv
module seq_phase_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_i,
  input  logic [CNT_W-1:0] seed_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expire_o = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q - 1'b1;
    if (seed_i)        cnt_d = seed_val_i;
    else if (expire_o) cnt_d = reload_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_i && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/hold_toggle_sequencer.sv
module hold_toggle_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned CNT_W = SEQ_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_start_i,
  input  logic [CNT_W-1:0] hold_code_i,
  input  logic [CNT_W-1:0] toggle_code_i,
  input  logic             start_mode_i,
  input  logic [CNT_W-1:0] offset_i,
  output logic             mode_o,
  output logic             first_cycle_o
);
  localparam logic [CNT_W-1:0] NO_HOLD_CODE = '0;

  logic             rst_sync_n;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload_val;
  seq_mode_e        mode_q;
  logic             no_hold;
  logic             first_q, first_d;

  seq_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Per-bit source select: the code for the mode that is entered next.
  for (genvar b = 0; b < CNT_W; b++) begin : g_src_mux
    assign reload_val[b] = (mode_q == SEQ_TOGGLE) ? hold_code_i[b] : toggle_code_i[b];
  end

  seq_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .seed_i       (pat_start_i),
    .seed_val_i   (offset_i),
    .reload_val_i (reload_val),
    .expire_o     (expire),
    .cnt_o        (cnt)
  );

  seq_mode_tff u_tff (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .init_i      (pat_start_i),
    .init_mode_i (seq_mode_e'(start_mode_i)),
    .flip_i      (expire),
    .mode_o      (mode_q)
  );

  assign no_hold = (hold_code_i == NO_HOLD_CODE);
  assign mode_o  = (mode_q == SEQ_TOGGLE) || no_hold;

  always_comb first_d = pat_start_i;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) first_q <= 1'b0;
    else             first_q <= first_d;
  end

  assign first_cycle_o = first_q;

  p_start_seeds_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pat_start_i |=> (mode_q == seq_mode_e'($past(start_mode_i)) && cnt == $past(offset_i)));
  p_start_wins_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pat_start_i && expire) |=> (cnt == $past(offset_i)));
  p_hold_reload_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pat_start_i && expire && mode_q == SEQ_TOGGLE) |=> (cnt == $past(hold_code_i)));
  p_toggle_reload_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pat_start_i && expire && mode_q == SEQ_HOLD) |=> (cnt == $past(toggle_code_i)));
  p_strobe_mode_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    first_cycle_o |-> (mode_q == seq_mode_e'($past(start_mode_i))));
endmodule

// File: tb/hold_toggle_sequencer_test.sv
module hold_toggle_sequencer_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pat_start;
  logic [W-1:0] hold_code, tog_code, offset;
  logic         start_mode;
  logic         mode_o, first_cycle_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic         m_mode;
  logic [W-1:0] m_cnt;
  logic         m_fc;

  always #2 clk = ~clk;

  hold_toggle_sequencer #(.CNT_W(W)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pat_start_i   (pat_start),
    .hold_code_i   (hold_code),
    .toggle_code_i (tog_code),
    .start_mode_i  (start_mode),
    .offset_i      (offset),
    .mode_o        (mode_o),
    .first_cycle_o (first_cycle_o)
  );

  function automatic logic exp_mode(logic md, logic [W-1:0] hc);
    return md | (hc == '0);
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive at negedge, advance one edge, update model, compare at next negedge.
  task automatic step(logic ps, logic [W-1:0] hc, logic [W-1:0] tc,
                      logic sm, logic [W-1:0] off, string tag);
    pat_start = ps; hold_code = hc; tog_code = tc; start_mode = sm; offset = off;
    @(posedge clk);
    if (ps) begin
      m_mode = sm; m_cnt = off;
    end else if (m_cnt == '0) begin
      m_mode = ~m_mode;
      m_cnt  = m_mode ? tc : hc;
    end else begin
      m_cnt = m_cnt - 1'b1;
    end
    m_fc = ps;
    @(negedge clk);
    check(tag, "mode_o", mode_o, exp_mode(m_mode, hc));
    check("R3", "first_cycle_o", first_cycle_o, m_fc);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; pat_start = 1'b0; hold_code = 4'd3; tog_code = 4'd2;
    start_mode = 1'b0; offset = 4'd0;
    m_mode = 1'b1; m_cnt = '0; m_fc = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "mode_o in reset", mode_o, 1'b1);
    check("R1", "first_cycle_o in reset", first_cycle_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2/R4: start in hold with offset 3, then durations hold 5, toggle 2.
    step(1'b1, 4'd5, 4'd2, 1'b0, 4'd3, "R2");
    for (int i = 0; i < 20; i++) step(1'b0, 4'd5, 4'd2, 1'b0, 4'd0, "R4");
    // start in toggle
    step(1'b1, 4'd4, 4'd6, 1'b1, 4'd1, "R2");
    for (int i = 0; i < 20; i++) step(1'b0, 4'd4, 4'd6, 1'b1, 4'd0, "R5");

    // R6: zero codes give one-cycle intervals (hold must stay non-zero to be seen).
    step(1'b1, 4'd1, 4'd0, 1'b1, 4'd0, "R6");
    for (int i = 0; i < 12; i++) step(1'b0, 4'd1, 4'd0, 1'b0, 4'd0, "R6");

    // R7: no-hold code keeps toggle, then sequencing visible again.
    step(1'b1, 4'd0, 4'd2, 1'b0, 4'd2, "R7");
    for (int i = 0; i < 15; i++) step(1'b0, 4'd0, 4'd2, 1'b0, 4'd0, "R7");
    for (int i = 0; i < 10; i++) step(1'b0, 4'd3, 4'd2, 1'b0, 4'd0, "R7");

    // R8: second start lands exactly on counter expiry (offset 0).
    step(1'b1, 4'd7, 4'd7, 1'b1, 4'd0, "R8");
    step(1'b1, 4'd7, 4'd7, 1'b1, 4'd5, "R8");
    for (int i = 0; i < 6; i++) step(1'b0, 4'd7, 4'd7, 1'b1, 4'd0, "R8");

    // R9: toggle code changes mid interval; only the next reload sees it.
    step(1'b1, 4'd2, 4'd9, 1'b0, 4'd0, "R9");
    step(1'b0, 4'd2, 4'd9, 1'b0, 4'd0, "R9");
    for (int i = 0; i < 4; i++) step(1'b0, 4'd2, 4'd1, 1'b0, 4'd0, "R9");
    for (int i = 0; i < 12; i++) step(1'b0, 4'd2, 4'd1, 1'b0, 4'd0, "R9");

    // Random mix.
    for (int i = 0; i < 4000; i++) begin
      logic ps;
      logic [W-1:0] hc;
      ps = ($urandom_range(0, 15) == 0);
      hc = ($urandom_range(0, 9) == 0) ? 4'd0 : 4'($urandom_range(1, 15));
      step(ps, hc, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           4'($urandom_range(0, 15)), "R5");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule